// File: doc/BRIEF.md
# VLIW Bundle Slot Dispersal Unit

This block sits between instruction fetch and issue in a wide-issue core. It takes in fixed 128-bit bundles, each with the address it was fetched from. A 5-bit template code inside each bundle is decoded through a constant lookup table. The code gives the execution-unit class of every slot and tells where stop marks fall. A stop mark closes the current instruction group. The block cuts the slot stream at those marks and hands the pieces on to issue, one group per output handshake.

Groups follow the stop marks, not the bundle edges. A bundle whose last slot carries no stop leaves its group open, and the slots of the next bundle join that group. A group holds at most six slots. When a group fills before a stop arrives, it is cut at six, and the remaining slots start the next group.

Two template codes describe a bundle with only two slots: one ordinary slot and one double-width slot. The block rejects two kinds of bad input and flags each with a one-cycle error pulse, then discards the bundle:
- a bundle that uses a reserved template code;
- a bundle whose address is not on a 16-byte boundary, which is how a branch into the middle of a bundle shows up here.

Top module: `vliw_disperse`

## Requirements
- R1: After reset, `out_valid`, `err_tmpl` and `err_align` are 0 and `in_ready` is 1.
- R2: Bundle layout: the template code is in bits 4:0, slot 0 in bits 45:5, slot 1 in bits 86:46 and slot 2 in bits 127:87. Each output slot carries its payload zero-extended to 82 bits. Slots leave in program order, and the first slot of a group appears at output position 0.
- R3: The template code is {pattern[3:0], end_stop}. When end_stop is 1, there is a stop after the bundle's last slot. Unit encoding: memory=0, integer=1, floating point=2, branch=3. Slot units by pattern, slot 0 first: 0 M I I; 1 M I I; 2 M + wide; 3 M M I; 4 M M I; 5 M F I; 6 M M F; 7 M I B; 8 M B B; 9 B B B; 10 M M B; 11 M F B.
- R4: Pattern 1 has a stop after slot 1, and pattern 4 has a stop after slot 0. Slots on either side of any stop leave in different groups, and a stop can only sit on the last slot of a group.
- R5: Pattern 2 (codes 4 and 5) yields two slots. The first is slot 0 with unit memory. The second has unit integer, `out_wide` set, and bits 127:46 of the bundle as its payload.
- R6: When a bundle has no stop after its last slot, its trailing slots and the slots of the next bundle go out in the same group.
- R7: A group that reaches 6 slots is emitted without waiting for a stop. The remaining slots of that bundle open the next group.
- R8: Codes 24 to 31 are reserved. Accepting such a bundle raises `err_tmpl` for exactly the following cycle, and the bundle contributes no slots.
- R9: Accepting a bundle whose address has nonzero bits 3:0 raises `err_align` for exactly the following cycle, and the bundle contributes no slots. Both errors may pulse together.
- R10: While `out_valid` is 1 and `out_ready` is 0, the group and its slot mask stay unchanged.
- R11: Whenever `out_valid` is 1, `out_slot_valid` is a nonzero mask that is contiguous from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken this cycle |
| in_bundle | input | 128 | Bundle bits |
| in_addr | input | 64 | Fetch address of the bundle |
| out_valid | output | 1 | A closed group is presented |
| out_ready | input | 1 | Issue takes the group |
| out_slot_valid | output | 6 | Occupied group positions |
| out_unit | output | 12 | Unit class, 2 bits per position |
| out_wide | output | 6 | Position holds a double-width slot |
| out_payload | output | 492 | Slot bits, 82 per position |
| err_tmpl | output | 1 | Reserved template seen |
| err_align | output | 1 | Misaligned bundle address seen |

## Verification
The assertions assume that `out_ready` is the only thing that releases a closed group. They also assume that a stream which must be drained ends with a stop; without one, the last open group is never released. Every directed scenario ends its stream with a stop-bearing template. Error pulses are checked only in relation to an accepted bundle. The bench offers each bundle only while `in_ready` is high and holds `out_ready` low for several cycles before taking each group, so the hold property is exercised on every group.

// File: rtl/disp_pkg.sv
// Shared constants and types for the bundle dispersal unit.
// Assumes the fixed 5-bit template / three 41-bit slot bundle layout.
package disp_pkg;
    localparam int TMPL_W   = 5;
    localparam int SLOT_W   = 41;
    localparam int SLOTS    = 3;
    localparam int WIDE_W   = 2 * SLOT_W;
    localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W;

    typedef enum logic [1:0] {
        UNIT_MEM = 2'd0,
        UNIT_INT = 2'd1,
        UNIT_FP  = 2'd2,
        UNIT_BR  = 2'd3
    } unit_e;

    // One dispersed slot: payload, unit class, width flag and stop-after flag.
    typedef struct packed {
        logic              stop;
        logic              wide;
        unit_e             unit;
        logic [WIDE_W-1:0] pay;
    } slot_t;

    // One decoded template row.
    typedef struct packed {
        logic                  legal;
        logic                  two_slot;
        logic [SLOTS-1:0]      stop;
        logic [SLOTS-1:0][1:0] unit;
    } tmpl_t;
endpackage

// File: rtl/disp_decode.sv
// Template lookup and slot extraction.
// Purely combinational. Assumes the template code sits in the low bits of the
// bundle and the slots follow it in program order.
module disp_decode
    import disp_pkg::*;
#(
    parameter int PC_W = 2
) (
    input  logic [BUNDLE_W-1:0] bundle,
    output slot_t [SLOTS-1:0]   ent,
    output logic [PC_W-1:0]     ent_cnt,
    output logic                legal
);
    tmpl_t             t;
    logic              e;
    logic [TMPL_W-1:0] code;

    assign code = bundle[TMPL_W-1:0];
    assign e    = code[0];

    // Builds one table row from unit classes, stop bits and the two-slot flag.
    function automatic tmpl_t row(input unit_e u0, input unit_e u1, input unit_e u2,
                                  input logic [SLOTS-1:0] s, input logic two);
        tmpl_t r;
        r.legal    = 1'b1;
        r.two_slot = two;
        r.stop     = s;
        r.unit     = {u2, u1, u0};
        return r;
    endfunction

    // Constant template ROM indexed by the pattern field (code bits 4:1).
    always_comb begin
        case (code[4:1])
            4'd0:    t = row(UNIT_MEM, UNIT_INT, UNIT_INT, {e, 1'b0, 1'b0}, 1'b0);
            4'd1:    t = row(UNIT_MEM, UNIT_INT, UNIT_INT, {e, 1'b1, 1'b0}, 1'b0);
            4'd2:    t = row(UNIT_MEM, UNIT_INT, UNIT_MEM, {1'b0, e, 1'b0}, 1'b1);
            4'd3:    t = row(UNIT_MEM, UNIT_MEM, UNIT_INT, {e, 1'b0, 1'b0}, 1'b0);
            4'd4:    t = row(UNIT_MEM, UNIT_MEM, UNIT_INT, {e, 1'b0, 1'b1}, 1'b0);
            4'd5:    t = row(UNIT_MEM, UNIT_FP,  UNIT_INT, {e, 1'b0, 1'b0}, 1'b0);
            4'd6:    t = row(UNIT_MEM, UNIT_MEM, UNIT_FP,  {e, 1'b0, 1'b0}, 1'b0);
            4'd7:    t = row(UNIT_MEM, UNIT_INT, UNIT_BR,  {e, 1'b0, 1'b0}, 1'b0);
            4'd8:    t = row(UNIT_MEM, UNIT_BR,  UNIT_BR,  {e, 1'b0, 1'b0}, 1'b0);
            4'd9:    t = row(UNIT_BR,  UNIT_BR,  UNIT_BR,  {e, 1'b0, 1'b0}, 1'b0);
            4'd10:   t = row(UNIT_MEM, UNIT_MEM, UNIT_BR,  {e, 1'b0, 1'b0}, 1'b0);
            4'd11:   t = row(UNIT_MEM, UNIT_FP,  UNIT_BR,  {e, 1'b0, 1'b0}, 1'b0);
            default: t = '0;
        endcase
    end

    // Splits the bundle into slot entries, folding the upper two slots into one
    // double-width slot for the two-slot patterns.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ent[i].pay  = WIDE_W'(bundle[TMPL_W + i*SLOT_W +: SLOT_W]);
            ent[i].unit = unit_e'(t.unit[i]);
            ent[i].stop = t.stop[i];
            ent[i].wide = 1'b0;
        end
        ent_cnt = PC_W'(SLOTS);
        if (t.two_slot) begin
            ent[1].pay  = bundle[BUNDLE_W-1 -: WIDE_W];
            ent[1].wide = 1'b1;
            ent[2]      = '0;
            ent_cnt     = PC_W'(2);
        end
    end

    assign legal = t.legal;
endmodule

// File: rtl/disp_pend.sv
// Pending-slot buffer.
// Holds the slots of one accepted bundle and releases, each cycle, a run of
// them from the head up to and including the first stop, limited by the room
// left in the group being built. Assumes a load only when the buffer is empty.
module disp_pend
    import disp_pkg::*;
#(
    parameter int PC_W = 2,
    parameter int FW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  slot_t [SLOTS-1:0]   load_ent,
    input  logic [PC_W-1:0]     load_cnt,
    input  logic [FW-1:0]       free,
    output slot_t [SLOTS-1:0]   head,
    output logic [PC_W-1:0]     take,
    output logic                take_stop,
    output logic                empty
);
    slot_t [SLOTS-1:0] pend;
    slot_t [SLOTS-1:0] nxt;
    logic [PC_W-1:0]   pend_cnt;
    logic [PC_W-1:0]   n_stop;

    // Finds the run length up to the first stop and clips it to the free room.
    always_comb begin
        n_stop = pend_cnt;
        for (int i = SLOTS-1; i >= 0; i--) begin
            if (PC_W'(i) < pend_cnt && pend[i].stop) n_stop = PC_W'(i+1);
        end
        take = (FW'(n_stop) > free) ? PC_W'(free) : n_stop;
        take_stop = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (PC_W'(i+1) == take && pend[i].stop) take_stop = 1'b1;
        end
    end

    // Shifts the remaining slots down to the head after a take.
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            nxt[j] = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (j + s < SLOTS && PC_W'(s) == take) nxt[j] = pend[j+s];
            end
        end
    end

    // Loads a new bundle or retires the slots just handed to the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            pend_cnt <= '0;
        end else if (load) begin
            pend     <= load_ent;
            pend_cnt <= load_cnt;
        end else begin
            pend     <= nxt;
            pend_cnt <= pend_cnt - take;
        end
    end

    assign head  = pend;
    assign empty = (pend_cnt == '0);

    // R4: a stop on the head slot lets only that slot into the current group.
    a_r4_stop_cuts_run: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0 && pend[0].stop && free != '0) |-> take == PC_W'(1));
endmodule

// File: rtl/disp_accum.sv
// Group accumulator.
// Appends released slots behind those already gathered. It closes the group
// when a stop arrives or the group is full, then holds the group on the
// output until the consumer takes it.
module disp_accum
    import disp_pkg::*;
#(
    parameter int GRP  = 6,
    parameter int PC_W = 2,
    parameter int FW   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slot_t [SLOTS-1:0]     head,
    input  logic [PC_W-1:0]       take,
    input  logic                  take_stop,
    output logic [FW-1:0]         free,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [GRP-1:0]        out_slot_valid,
    output logic [2*GRP-1:0]      out_unit,
    output logic [GRP-1:0]        out_wide,
    output logic [GRP*WIDE_W-1:0] out_payload
);
    slot_t [GRP-1:0] acc;
    logic [FW-1:0]   acc_cnt;
    logic            closed;
    logic            inner_stop;

    assign free = closed ? '0 : (FW'(GRP) - acc_cnt);

    // Clears after a handshake, otherwise appends released slots and decides closure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            acc_cnt <= '0;
            closed  <= 1'b0;
        end else if (closed && out_ready) begin
            acc_cnt <= '0;
            closed  <= 1'b0;
        end else if (take != '0) begin
            for (int k = 0; k < GRP; k++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (FW'(k) == acc_cnt + FW'(s) && FW'(s) < FW'(take)) acc[k] <= head[s];
                end
            end
            acc_cnt <= acc_cnt + FW'(take);
            closed  <= take_stop || (acc_cnt + FW'(take) == FW'(GRP));
        end
    end

    // Flattens the gathered group onto the output buses.
    for (genvar k = 0; k < GRP; k++) begin : g_out
        assign out_slot_valid[k]               = closed && (FW'(k) < acc_cnt);
        assign out_unit[2*k +: 2]              = acc[k].unit;
        assign out_wide[k]                     = acc[k].wide;
        assign out_payload[k*WIDE_W +: WIDE_W] = acc[k].pay;
    end

    assign out_valid = closed;

    // Flags any stop sitting before the last occupied position.
    always_comb begin
        inner_stop = 1'b0;
        for (int k = 0; k < GRP; k++) begin
            if (FW'(k+1) < acc_cnt && acc[k].stop) inner_stop = 1'b1;
        end
    end

    // R10: a presented group is frozen until taken.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)
                                       && $stable(out_slot_valid) && $stable(out_unit)));
    // R11: occupied positions form a nonzero prefix.
    a_r11_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_valid != '0
                       && ((out_slot_valid & (out_slot_valid + 1'b1)) == '0)));
    // R4: no stop inside a group, only possibly on its last slot.
    a_r4_no_inner_stop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !inner_stop);
    // R7: a group never grows past its capacity.
    a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= FW'(GRP));
endmodule

// File: rtl/vliw_disperse.sv
// Bundle dispersal top level.
// Checks each accepted bundle for a legal template and a bundle-aligned
// address, decodes it into tagged slots and regroups the slots at stop marks.
// Assumes the consumer drains groups through out_ready.
module vliw_disperse
    import disp_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int GRP    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [BUNDLE_W-1:0]   in_bundle,
    input  logic [ADDR_W-1:0]     in_addr,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [GRP-1:0]        out_slot_valid,
    output logic [2*GRP-1:0]      out_unit,
    output logic [GRP-1:0]        out_wide,
    output logic [GRP*WIDE_W-1:0] out_payload,
    output logic                  err_tmpl,
    output logic                  err_align
);
    localparam int PC_W       = $clog2(SLOTS + 1);
    localparam int FW         = $clog2(GRP + SLOTS + 1);
    localparam int ALIGN_BITS = $clog2(BUNDLE_W / 8);

    slot_t [SLOTS-1:0] dec_ent;
    slot_t [SLOTS-1:0] head;
    logic [PC_W-1:0]   dec_cnt;
    logic [PC_W-1:0]   take;
    logic [FW-1:0]     free;
    logic              legal, take_stop, empty;
    logic              accept, misalign, load;

    assign accept   = in_valid && in_ready;
    assign misalign = (in_addr[ALIGN_BITS-1:0] != '0);
    assign load     = accept && legal && !misalign;
    assign in_ready = empty;

    disp_decode #(.PC_W(PC_W)) u_dec (
        .bundle  (in_bundle),
        .ent     (dec_ent),
        .ent_cnt (dec_cnt),
        .legal   (legal)
    );

    disp_pend #(.PC_W(PC_W), .FW(FW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_ent  (dec_ent),
        .load_cnt  (dec_cnt),
        .free      (free),
        .head      (head),
        .take      (take),
        .take_stop (take_stop),
        .empty     (empty)
    );

    disp_accum #(.GRP(GRP), .PC_W(PC_W), .FW(FW)) u_acc (
        .clk            (clk),
        .rst_n          (rst_n),
        .head           (head),
        .take           (take),
        .take_stop      (take_stop),
        .free           (free),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_slot_valid (out_slot_valid),
        .out_unit       (out_unit),
        .out_wide       (out_wide),
        .out_payload    (out_payload)
    );

    // Raises one-cycle error pulses for rejected bundles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_tmpl  <= 1'b0;
            err_align <= 1'b0;
        end else begin
            err_tmpl  <= accept && !legal;
            err_align <= accept && misalign;
        end
    end

    // R8: a template error only follows an accepted bundle.
    a_r8_err_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmpl |-> $past(in_valid && in_ready));
    // R9: an alignment error only follows an accepted bundle.
    a_r9_err_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |-> $past(in_valid && in_ready));
endmodule

// File: tb/vliw_disperse_tb.sv
module vliw_disperse_tb;
    import disp_pkg::*;
    localparam int GRP = 6;
    localparam int AW  = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst_n, in_valid, in_ready, out_valid, out_ready, err_tmpl, err_align;
    logic [BUNDLE_W-1:0]   in_bundle;
    logic [AW-1:0]         in_addr;
    logic [GRP-1:0]        out_slot_valid, out_wide;
    logic [2*GRP-1:0]      out_unit;
    logic [GRP*WIDE_W-1:0] out_payload;

    vliw_disperse #(.ADDR_W(AW), .GRP(GRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .in_addr(in_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_slot_valid(out_slot_valid), .out_unit(out_unit),
        .out_wide(out_wide), .out_payload(out_payload), .err_tmpl(err_tmpl),
        .err_align(err_align)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int g_n;
    logic [1:0]        g_unit [GRP];
    logic              g_wide [GRP];
    logic [WIDE_W-1:0] g_pay  [GRP];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [SLOT_W-1:0] mk(input int n);
        return {9'(n), 32'hC0DE0000 + 32'(n)};
    endfunction

    // Offers one bundle, waits for acceptance, returns the error flags seen after it.
    task automatic send(input logic [4:0] code, input logic [SLOT_W-1:0] a, b, c,
                        input logic [AW-1:0] addr, output logic et, output logic ea);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_bundle = {c, b, a, code};
        in_addr   = addr;
        @(negedge clk);
        in_valid = 1'b0;
        et = err_tmpl;
        ea = err_align;
    endtask

    // Waits for a group, checks hold and prefix shape, captures it, takes it.
    task automatic get_group(input string tag);
        logic [GRP*WIDE_W-1:0] p0;
        logic [GRP-1:0]        v0;
        int t = 0;
        while (!out_valid && t < 200) begin @(negedge clk); t++; end
        chk(out_valid, {tag, " group appears"}, 128'(out_valid), 128'(1));
        p0 = out_payload; v0 = out_slot_valid;
        @(negedge clk); @(negedge clk);
        chk(out_valid && out_payload == p0 && out_slot_valid == v0,
            {tag, " R10 held while stalled"}, 128'(out_slot_valid), 128'(v0));
        chk(v0 != 0 && ((v0 & (v0 + 1'b1)) == 0), {tag, " R11 prefix mask"}, 128'(v0), 128'(v0));
        g_n = $countones(v0);
        for (int k = 0; k < GRP; k++) begin
            g_unit[k] = out_unit[2*k +: 2];
            g_wide[k] = out_wide[k];
            g_pay[k]  = out_payload[k*WIDE_W +: WIDE_W];
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic exp_slot(input int k, input logic [1:0] u, input logic w,
                            input logic [WIDE_W-1:0] p, input string tag);
        chk(g_unit[k] == u && g_wide[k] == w && g_pay[k] == p,
            $sformatf("%s pos%0d unit/wide/payload", tag, k),
            {44'(g_unit[k]), 2'(g_wide[k]), g_pay[k]}, {44'(u), 2'(w), p});
    endtask

    task automatic exp_count(input int n, input string tag);
        chk(g_n == n, {tag, " slot count"}, 128'(g_n), 128'(n));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_bundle = '0; in_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready && !err_tmpl && !err_align, "R1 reset state",
            {124'(0), out_valid, in_ready, err_tmpl, err_align}, 128'b0100);
    endtask

    // R2/R3: plain MII bundle with end stop, code 1.
    task automatic t_basic();
        logic et, ea;
        send(5'd1, mk(1), mk(2), mk(3), 64'h1000, et, ea);
        chk(!et && !ea, "R3 legal code no error", {126'(0), et, ea}, 128'(0));
        get_group("R2 basic");
        exp_count(3, "R2 basic");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(1)), "R2 basic");
        exp_slot(1, 2'd1, 1'b0, WIDE_W'(mk(2)), "R3 basic");
        exp_slot(2, 2'd1, 1'b0, WIDE_W'(mk(3)), "R3 basic");
    endtask

    // R4/R6: internal stops and a group crossing a bundle edge.
    task automatic t_mid_stop();
        logic et, ea;
        send(5'd3, mk(10), mk(11), mk(12), 64'h1010, et, ea);
        get_group("R4 pat1 first");
        exp_count(2, "R4 pat1 first");
        exp_slot(1, 2'd1, 1'b0, WIDE_W'(mk(11)), "R4 pat1 first");
        get_group("R4 pat1 second");
        exp_count(1, "R4 pat1 second");
        exp_slot(0, 2'd1, 1'b0, WIDE_W'(mk(12)), "R4 pat1 second");
        send(5'd8, mk(20), mk(21), mk(22), 64'h1020, et, ea);
        get_group("R4 pat4 first");
        exp_count(1, "R4 pat4 first");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(20)), "R4 pat4 first");
        send(5'd19, mk(30), mk(31), mk(32), 64'h1030, et, ea);
        get_group("R6 span");
        exp_count(5, "R6 span");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(21)), "R6 span");
        exp_slot(1, 2'd1, 1'b0, WIDE_W'(mk(22)), "R6 span");
        exp_slot(2, 2'd3, 1'b0, WIDE_W'(mk(30)), "R6 span");
        exp_slot(4, 2'd3, 1'b0, WIDE_W'(mk(32)), "R6 span");
    endtask

    // R5: two-slot bundle, code 5.
    task automatic t_long();
        logic et, ea;
        send(5'd5, mk(40), mk(41), mk(42), 64'h2000, et, ea);
        get_group("R5 long");
        exp_count(2, "R5 long");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(40)), "R5 long");
        exp_slot(1, 2'd1, 1'b1, {mk(42), mk(41)}, "R5 long");
    endtask

    // R7: capacity cut in the middle of the third bundle.
    task automatic t_full();
        logic et, ea;
        send(5'd0,  mk(50), mk(51), mk(52), 64'h3000, et, ea);
        send(5'd4,  mk(53), mk(54), mk(55), 64'h3010, et, ea);
        send(5'd15, mk(56), mk(57), mk(58), 64'h3020, et, ea);
        get_group("R7 full");
        exp_count(6, "R7 full");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(50)), "R7 full");
        exp_slot(2, 2'd1, 1'b0, WIDE_W'(mk(52)), "R7 full");
        exp_slot(4, 2'd1, 1'b1, {mk(55), mk(54)}, "R7 full");
        exp_slot(5, 2'd0, 1'b0, WIDE_W'(mk(56)), "R7 full");
        get_group("R7 rest");
        exp_count(2, "R7 rest");
        exp_slot(0, 2'd1, 1'b0, WIDE_W'(mk(57)), "R7 rest");
        exp_slot(1, 2'd3, 1'b0, WIDE_W'(mk(58)), "R7 rest");
    endtask

    // R8: reserved codes are flagged and dropped.
    task automatic t_reserved();
        logic et, ea;
        send(5'd24, mk(60), mk(61), mk(62), 64'h4000, et, ea);
        chk(et && !ea, "R8 code 24 flagged", {126'(0), et, ea}, 128'b10);
        @(negedge clk);
        chk(!err_tmpl, "R8 pulse one cycle", 128'(err_tmpl), 128'(0));
        send(5'd31, mk(63), mk(64), mk(65), 64'h4010, et, ea);
        chk(et, "R8 code 31 flagged", 128'(et), 128'(1));
        repeat (4) @(negedge clk);
        chk(!out_valid, "R8 no slots from reserved", 128'(out_valid), 128'(0));
        send(5'd1, mk(66), mk(67), mk(68), 64'h4020, et, ea);
        get_group("R8 after reserved");
        exp_count(3, "R8 after reserved");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(66)), "R8 after reserved");
    endtask

    // R9: misaligned addresses are flagged and dropped.
    task automatic t_misalign();
        logic et, ea;
        send(5'd1, mk(70), mk(71), mk(72), 64'h5004, et, ea);
        chk(!et && ea, "R9 misaligned flagged", {126'(0), et, ea}, 128'b01);
        send(5'd25, mk(73), mk(74), mk(75), 64'h5001, et, ea);
        chk(et && ea, "R9 both errors together", {126'(0), et, ea}, 128'b11);
        repeat (4) @(negedge clk);
        chk(!out_valid, "R9 no slots from misaligned", 128'(out_valid), 128'(0));
        send(5'd23, mk(76), mk(77), mk(78), 64'h5010, et, ea);
        get_group("R9 after misaligned");
        exp_count(3, "R9 after misaligned");
        exp_slot(0, 2'd0, 1'b0, WIDE_W'(mk(76)), "R9 after misaligned");
        exp_slot(1, 2'd2, 1'b0, WIDE_W'(mk(77)), "R3 pattern 11");
        exp_slot(2, 2'd3, 1'b0, WIDE_W'(mk(78)), "R3 pattern 11");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mid_stop();
        t_long();
        t_full();
        t_reserved();
        t_misalign();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule